// File: doc/BRIEF.md
# Dual Mode Pulse Accumulator

This block is a 16-bit accumulator that can work in one of two ways. In event mode it counts transitions on an external pin, taking that pin over from the seventh capture/compare channel of the timer. In gated mode it counts a slow prescaled tick, one count per tick, for as long as the same pin sits at its active level. The result is the elapsed gate time in units of that tick.

A polarity control picks the counted edge in event mode (rising or falling) and the active level in gated mode (high or low). Two sticky flags report results to software. One flag is set when the count wraps from all ones to zero. The other is set by the counted edge in event mode, or by the end of the gate in gated mode, so that software knows a measurement has completed. Each flag is cleared by a one-cycle clear pulse. Software can load the count directly at any time. The count holds its value while the block is disabled.

The pin is asynchronous to the block clock. It passes through a two-flop synchronizer and then an edge register before any decision is made. The reset input is asynchronous and active-low, and its release is synchronized to the clock inside the block.

Top module: `pulse_accum`

## Requirements
- R1: While reset is asserted, and on release, `count_o` is 0 and both `ovf_flag_o` and `evt_flag_o` are 0.
- R2: With `en_i`=1 and `mode_i`=0 (event), the count rises by one for each selected pin edge. `pol_i`=0 selects the rising edge and `pol_i`=1 the falling edge. The other edge and `tick_i` have no effect. The new count is visible after the third rising clock edge that follows the pin change.
- R3: With `en_i`=1 and `mode_i`=1 (gated), the count rises by one on each clock edge where `tick_i`=1 and the synchronized pin is at its active level. The active level is high for `pol_i`=0 and low for `pol_i`=1. Pin edges by themselves do not count.
- R4: An increment from 0xFFFF to 0x0000 sets `ovf_flag_o`. The flag stays set until a pulse on `ovf_clr_i`. If a set and a clear arrive in the same cycle, the set wins.
- R5: `evt_flag_o` is set by a counted edge in event mode. In gated mode it is set by the trailing edge of the gate (active to inactive), and the leading edge does not set it. It clears on an `evt_clr_i` pulse, and a set wins over a clear in the same cycle.
- R6: `wr_i`=1 loads `wr_data_i` into the count at the next clock edge, whatever the value of `en_i`. A load takes priority over an increment in the same cycle and never sets `ovf_flag_o`.
- R7: With `en_i`=0 the count holds, apart from loads, and neither flag is set.
- R8: Changing `pol_i` while the pin is steady does not count an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Accumulator enable |
| mode_i | input | 1 | 0 = event counting, 1 = gated time |
| pol_i | input | 1 | 0 = rising edge / high active, 1 = falling edge / low active |
| pin_i | input | 1 | External input shared with timer channel 7 (asynchronous) |
| tick_i | input | 1 | Prescaled tick pulse (clock divided by 64) for gated mode |
| wr_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 16 | Value loaded by `wr_i` |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| evt_clr_i | input | 1 | Clear pulse for the input flag |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| evt_flag_o | output | 1 | Sticky edge / gate-end flag |

## Verification
A pin change reaches the count and the input flag on the third rising clock edge after it, because of two synchronizer flops plus the edge register. A tick, a load or a clear pulse acts on the first edge. The bench drives every input on a falling edge and waits exactly that many falling edges before it samples. In the vector table, each row lets the pin settle for three cycles before any tick is issued, so gated counts never depend on a pin that is still crossing the synchronizer.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic {
    PA_EVENT = 1'b0,
    PA_GATED = 1'b1
  } pa_mode_e;

  // synchronized pin view, already folded with the polarity control
  typedef struct packed {
    logic level;  // pin at active level
    logic lead;   // inactive -> active this cycle
    logic trail;  // active -> inactive this cycle
  } pa_pin_s;

endpackage

// File: rtl/pa_rstsync.sv
module pa_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/pa_insync.sv
module pa_insync
  import pa_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_i,
  input  logic    pol_i,
  output pa_pin_s pin_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              hist_q;
  logic              hist_d;
  logic              lvl_now;
  logic              lvl_prev;

  // next-state
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    hist_d = sync_q[STAGES-1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  // both samples are folded with the present polarity, so a polarity
  // change alone never produces an edge
  always_comb begin
    lvl_now     = sync_q[STAGES-1] ^ pol_i;
    lvl_prev    = hist_q ^ pol_i;
    pin_o.level = lvl_now;
    pin_o.lead  = lvl_now & ~lvl_prev;
    pin_o.trail = ~lvl_now & lvl_prev;
  end

  // R2
  single_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_o.lead |=> (!pin_o.lead || !$stable(pol_i)));

  // R8
  pol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(sync_q[STAGES-1]) && $stable(hist_q) && (sync_q[STAGES-1] == hist_q))
      |-> (!pin_o.lead && !pin_o.trail));

endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  pa_mode_e mode_i,
  input  logic     tick_i,
  input  pa_pin_s  pin_i,
  output logic     inc_o,
  output logic     evt_o
);

  always_comb begin
    inc_o = 1'b0;
    evt_o = 1'b0;
    if (en_i) begin
      case (mode_i)
        PA_EVENT: begin
          inc_o = pin_i.lead;
          evt_o = pin_i.lead;
        end
        PA_GATED: begin
          inc_o = tick_i & pin_i.level;
          evt_o = pin_i.trail;
        end
        default: begin
          inc_o = 1'b0;
          evt_o = 1'b0;
        end
      endcase
    end
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!inc_o && !evt_o));

  // R3
  gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PA_GATED && inc_o) |-> (tick_i && pin_i.level));

endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  // next-state: a load beats an increment
  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    cnt_en = wr_i | inc_i;
    if (wr_i) begin
      cnt_d = wr_data_i;
    end else if (inc_i) begin
      cnt_d  = cnt_q + ONE;
      wrap_o = &cnt_q;
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_o == $past(wr_data_i)));

  // R2 R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i) |=> (cnt_o == $past(cnt_o) + ONE));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pa_flag.sv
module pa_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R4 R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R4 R5
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             pin_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  input  logic             evt_clr_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             evt_flag_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic     rst_n;
  pa_mode_e mode;
  pa_pin_s  pin_s;
  logic     inc;
  logic     evt;
  logic     wrap;

  assign mode = pa_mode_e'(mode_i);

  pa_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pa_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .pol_i (pol_i),
    .pin_o (pin_s)
  );

  pa_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .mode_i (mode),
    .tick_i (tick_i),
    .pin_i  (pin_s),
    .inc_o  (inc),
    .evt_o  (evt)
  );

  pa_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .inc_i     (inc),
    .cnt_o     (count_o),
    .wrap_o    (wrap)
  );

  pa_flag u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wrap),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_flag_o)
  );

  pa_flag u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt),
    .clr_i  (evt_clr_i),
    .flag_o (evt_flag_o)
  );

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> (($past(count_o) == ALL_ONES) && (count_o == '0)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_i) |=> $stable(count_o));

  // R7
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!$rose(evt_flag_o) && !$rose(ovf_flag_o)));

  // R1
  always_comb begin
    if (!arst_n) begin
      reset_state_chk: assert (!ovf_flag_o && !evt_flag_o && count_o == '0);
    end
  end

endmodule

// File: tb/pulse_accum_test.sv
module pulse_accum_test;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        en_i, mode_i, pol_i, pin_i, tick_i, wr_i;
  logic [15:0] wr_data_i;
  logic        ovf_clr_i, evt_clr_i;
  logic [15:0] count_o;
  logic        ovf_flag_o, evt_flag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pulse_accum uut (
    .clk(clk), .arst_n(arst_n), .en_i(en_i), .mode_i(mode_i), .pol_i(pol_i),
    .pin_i(pin_i), .tick_i(tick_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .ovf_clr_i(ovf_clr_i), .evt_clr_i(evt_clr_i), .count_o(count_o),
    .ovf_flag_o(ovf_flag_o), .evt_flag_o(evt_flag_o)
  );

  // {gated, pol, pin, ticks[3:0], expected count[15:0]}
  localparam int NVEC = 11;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 4'd0, 16'd1},   // R2 rising counted
    {1'b0, 1'b0, 1'b0, 4'd0, 16'd1},   // R2 falling ignored
    {1'b0, 1'b0, 1'b1, 4'd2, 16'd2},   // R2 ticks ignored in event mode
    {1'b0, 1'b0, 1'b0, 4'd0, 16'd2},
    {1'b0, 1'b1, 1'b1, 4'd0, 16'd2},   // R2 rising ignored, pol=1
    {1'b0, 1'b1, 1'b0, 4'd0, 16'd3},   // R2 falling counted, pol=1
    {1'b1, 1'b0, 1'b0, 4'd3, 16'd3},   // R3 gate inactive
    {1'b1, 1'b0, 1'b1, 4'd4, 16'd7},   // R3 gate high active
    {1'b1, 1'b0, 1'b0, 4'd2, 16'd7},
    {1'b1, 1'b1, 1'b0, 4'd5, 16'd12},  // R3 gate low active
    {1'b1, 1'b1, 1'b1, 4'd3, 16'd12}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v);
    wr_i = 1'b1; wr_data_i = v;
    cyc(1);
    wr_i = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    pin_i = v;
    cyc(3);
  endtask

  task automatic pulse_evt_clr();
    evt_clr_i = 1'b1; cyc(1); evt_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; en_i = 1'b0; mode_i = 1'b0; pol_i = 1'b0; pin_i = 1'b0;
    tick_i = 1'b0; wr_i = 1'b0; wr_data_i = '0; ovf_clr_i = 1'b0; evt_clr_i = 1'b0;
    cyc(3);
    chk({14'd0, ovf_flag_o, evt_flag_o, count_o}, 32'd0, "R1 in reset");
    arst_n = 1'b1;
    cyc(4);
    chk({14'd0, ovf_flag_o, evt_flag_o, count_o}, 32'd0, "R1 after release");

    en_i = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      mode_i = VEC[i][22];
      pol_i  = VEC[i][21];
      set_pin(VEC[i][20]);
      for (int t = 0; t < int'(VEC[i][19:16]); t++) begin
        tick_i = 1'b1; cyc(1); tick_i = 1'b0; cyc(1);
      end
      chk({16'd0, count_o}, {16'd0, VEC[i][15:0]}, VEC[i][22] ? "R3 vector" : "R2 vector");
    end

    // R5 clear
    pulse_evt_clr();
    chk({31'd0, evt_flag_o}, 32'd0, "R5 clear");

    // R6 load, R8 polarity change with steady pin (pin is 1)
    load(16'hFFFE);
    chk({16'd0, count_o}, 32'h0000FFFE, "R6 load");
    mode_i = 1'b0; pol_i = 1'b0;
    cyc(3);
    chk({16'd0, count_o}, 32'h0000FFFE, "R8 polarity swap");
    chk({31'd0, evt_flag_o}, 32'd0, "R8 no flag");

    // R2 / R4 wrap in event mode
    set_pin(1'b0);
    set_pin(1'b1);
    chk({16'd0, count_o}, 32'h0000FFFF, "R2 edge");
    chk({31'd0, ovf_flag_o}, 32'd0, "R4 no early wrap");
    set_pin(1'b0);
    set_pin(1'b1);
    chk({16'd0, count_o}, 32'd0, "R4 wrap count");
    chk({31'd0, ovf_flag_o}, 32'd1, "R4 wrap flag");
    chk({31'd0, evt_flag_o}, 32'd1, "R5 event edge flag");
    ovf_clr_i = 1'b1; cyc(1); ovf_clr_i = 1'b0;
    chk({31'd0, ovf_flag_o}, 32'd0, "R4 clear");
    pulse_evt_clr();

    // R7 disabled
    en_i = 1'b0;
    set_pin(1'b0);
    set_pin(1'b1);
    chk({16'd0, count_o}, 32'd0, "R7 event hold");
    chk({31'd0, evt_flag_o}, 32'd0, "R7 no flag");
    mode_i = 1'b1;
    tick_i = 1'b1; cyc(2); tick_i = 1'b0; cyc(1);
    chk({16'd0, count_o}, 32'd0, "R7 gated hold");
    load(16'h1234);
    chk({16'd0, count_o}, 32'h00001234, "R6 load while disabled");

    // R6 priority over tick; R3 tick alone (gated, pol 0, pin 1)
    en_i = 1'b1;
    cyc(3);
    tick_i = 1'b1; wr_i = 1'b1; wr_data_i = 16'h0100;
    cyc(1);
    wr_i = 1'b0; tick_i = 1'b0;
    chk({16'd0, count_o}, 32'h00000100, "R6 load beats tick");
    tick_i = 1'b1; cyc(1); tick_i = 1'b0;
    chk({16'd0, count_o}, 32'h00000101, "R3 single tick");

    // R5 gated: trailing edge sets, leading does not
    pulse_evt_clr();
    set_pin(1'b0);
    chk({31'd0, evt_flag_o}, 32'd1, "R5 gate end");
    pulse_evt_clr();
    set_pin(1'b1);
    chk({31'd0, evt_flag_o}, 32'd0, "R5 gate start");

    // R4 set beats clear; R6 load sets no overflow
    load(16'hFFFF);
    chk({31'd0, ovf_flag_o}, 32'd0, "R6 load no overflow");
    tick_i = 1'b1; ovf_clr_i = 1'b1; cyc(1); tick_i = 1'b0; ovf_clr_i = 1'b0;
    chk({16'd0, count_o}, 32'd0, "R4 gated wrap count");
    chk({31'd0, ovf_flag_o}, 32'd1, "R4 set beats clear");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule